// File: doc/BRIEF.md
# Link Power State Sequencer

This block sits on the controller side of a PIPE-style PHY and manages link power states. Upper control logic hands it a target power state over a valid/ready request channel. The block drives that state onto the 2-bit powerdown code toward the PHY. It then waits for the PHY's single-cycle completion pulse before it takes the next request. The request channel has back-pressure: `req_ready` is low from the edge that accepts a request until the edge that sees completion or timeout. A request presented while `req_ready` is low is not forwarded. The requester must keep `req_valid` high, or present it again later.

The block tracks the confirmed power state. In that state it drives the transmitter electrical-idle and detect/loopback controls to legal levels, built from the levels upper logic asks for. A combination that is illegal for the state is replaced by the state's default, and a sticky error is raised. A programmable watchdog limits how long the block waits for completion. If the pulse never comes, the block gives up, puts the previous code back on the powerdown lines and sets a sticky timeout error.

Top module: `link_pwr_sequencer`

## Requirements
- R1: After reset: `phy_powerdown`=2'b11, `cur_state`=2'b11 (P2), `busy`=0, `req_ready`=1, `phy_tx_idle`=1, `phy_tx_detlb`=0, and both error flags are 0.
- R2: The state codes are P0=2'b00, P0s=2'b01, P1=2'b10 and P2=2'b11. A request is accepted on an edge where `req_valid`=1 and `req_ready`=1. From the next cycle, `phy_powerdown` carries the requested code and `busy` is 1.
- R3: While `busy`=1, `req_ready` is 0. A pending `req_valid` with any code leaves `phy_powerdown` unchanged and is not accepted.
- R4: `cur_state` takes the requested code only on the edge where `phy_done`=1 while `busy`=1, and `busy` falls on that same edge. A `phy_done` while not busy has no effect.
- R5: While `cur_state` is P0, `phy_tx_detlb` follows `want_detlb` and `phy_tx_idle` follows `want_idle`, one cycle later, and no error is raised.
- R6: While `cur_state` is P0s, `phy_tx_detlb`=0 and `phy_tx_idle`=1. A request with `want_detlb`=1 or `want_idle`=0 sets `err_illegal`.
- R7: While `cur_state` is P1, `phy_tx_idle`=1 and `phy_tx_detlb` follows `want_detlb` one cycle later. `want_idle`=0 sets `err_illegal`.
- R8: While `cur_state` is P2, `phy_tx_detlb`=0 and `phy_tx_idle` is the inverse of `want_beacon` one cycle later. `want_idle` is ignored, and `want_detlb`=1 sets `err_illegal`. In any other state, `want_beacon` has no effect.
- R9: If `busy` has been high for `done_limit` cycles with no `phy_done`, then `busy` falls, `err_timeout` is set, `phy_powerdown` returns to the `cur_state` code and `cur_state` is unchanged. A `done_limit` of 0 behaves as 1. When `phy_done` arrives on the expiry edge, it wins.
- R10: `err_illegal` and `err_timeout` stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Power state request present |
| req_ready | output | 1 | Request can be accepted |
| req_state | input | 2 | Requested power state code |
| want_detlb | input | 1 | Requested detect/loopback level |
| want_idle | input | 1 | Requested electrical-idle level |
| want_beacon | input | 1 | Beacon request (used in P2 only) |
| done_limit | input | TW | Completion timeout in cycles |
| phy_done | input | 1 | PHY completion pulse |
| phy_powerdown | output | 2 | Powerdown code to the PHY |
| phy_tx_detlb | output | 1 | Detect/loopback control to the PHY |
| phy_tx_idle | output | 1 | Electrical-idle control to the PHY |
| cur_state | output | 2 | Confirmed power state |
| busy | output | 1 | Transition in progress |
| err_illegal | output | 1 | Sticky illegal-control error |
| err_timeout | output | 1 | Sticky completion-timeout error |

## Verification
The hardest case to reach is a request that is still waiting when a transition ends. If `req_valid` is held high while busy, a new code could slip through on the completion edge. To cover this, the stimulus keeps `req_valid` high with a changing code across a busy window. It drops `req_valid` on the cycle that pulses `phy_done`. The timeout path is reached by shrinking `done_limit` to 4 and then 0 and never answering the request. A stray completion pulse that follows must then be ignored.

// File: rtl/lps_pkg.sv
package lps_pkg;
  typedef enum logic [1:0] {
    PS_P0  = 2'b00,
    PS_P0S = 2'b01,
    PS_P1  = 2'b10,
    PS_P2  = 2'b11
  } pstate_e;
endpackage

// File: rtl/lps_done_watchdog.sv
module lps_done_watchdog #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          busy,
  input  logic          phy_done,
  input  logic [TW-1:0] limit,
  output logic          expire
);
  localparam int CW = TW + 1;

  logic [TW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;

  // cycles spent waiting, counting the one now ending
  assign cnt_nxt = {1'b0, cnt_q} + {{TW{1'b0}}, 1'b1};
  assign expire  = busy && !phy_done && (cnt_nxt >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (start)           cnt_q <= '0;
    else if (busy && !expire) cnt_q <= cnt_nxt[TW-1:0];
  end

  // R9: the count never runs past the limit while a transition waits
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $stable(limit) && limit != '0) |-> (cnt_q < limit));
endmodule

// File: rtl/lps_req_ctrl.sv
module lps_req_ctrl
  import lps_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  pstate_e req_state,
  output logic    req_ready,
  input  logic    phy_done,
  input  logic    expire,
  output logic    start,
  output logic    busy_q,
  output pstate_e pd_q,
  output pstate_e cur_q,
  output logic    err_timeout_q
);
  assign req_ready = !busy_q;
  assign start     = req_valid && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q        <= 1'b0;
      pd_q          <= PS_P2;
      cur_q         <= PS_P2;
      err_timeout_q <= 1'b0;
    end else if (busy_q && phy_done) begin
      cur_q  <= pd_q;
      busy_q <= 1'b0;
    end else if (expire) begin
      busy_q        <= 1'b0;
      pd_q          <= cur_q;
      err_timeout_q <= 1'b1;
    end else if (start) begin
      pd_q   <= req_state;
      busy_q <= 1'b1;
    end
  end

  // R2: an accepted request appears on the powerdown code next cycle
  a_r2_issue: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy_q && pd_q == $past(req_state)));
  // R3: a waiting transition keeps its code whatever arrives on the request side
  a_r3_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !phy_done && !expire) |=> (busy_q && $stable(pd_q)));
  // R4: the confirmed state moves only on completion
  a_r4_state_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && phy_done) |=> $stable(cur_q));
  // R9: expiry releases busy, flags and restores the previous code
  a_r9_timeout: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (!busy_q && err_timeout_q && pd_q == $past(cur_q)));
  // R10: timeout error is sticky
  a_r10_to_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout_q |=> err_timeout_q);
endmodule

// File: rtl/lps_tx_gate.sv
module lps_tx_gate
  import lps_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  pstate_e cur,
  input  logic    want_detlb,
  input  logic    want_idle,
  input  logic    want_beacon,
  output logic    tx_detlb_q,
  output logic    tx_idle_q,
  output logic    err_illegal_q
);
  logic det_d, idle_d, bad_d;

  always_comb begin
    det_d  = 1'b0;
    idle_d = 1'b1;
    bad_d  = 1'b0;
    unique case (cur)
      PS_P0: begin
        det_d  = want_detlb;
        idle_d = want_idle;
      end
      PS_P0S: begin
        bad_d = want_detlb || !want_idle;
      end
      PS_P1: begin
        det_d = want_detlb;
        bad_d = !want_idle;
      end
      PS_P2: begin
        idle_d = !want_beacon;
        bad_d  = want_detlb;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_detlb_q    <= 1'b0;
      tx_idle_q     <= 1'b1;
      err_illegal_q <= 1'b0;
    end else begin
      tx_detlb_q <= det_d;
      tx_idle_q  <= idle_d;
      if (bad_d) err_illegal_q <= 1'b1;
    end
  end

  // R6: legal levels forced in P0s
  a_r6_p0s_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == PS_P0S) |=> (!tx_detlb_q && tx_idle_q));
  // R7: electrical idle held in P1
  a_r7_p1_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == PS_P1) |=> tx_idle_q);
  // R8: idle only dropped for a beacon in P2
  a_r8_p2_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == PS_P2) |=> (tx_idle_q == !$past(want_beacon) && !tx_detlb_q));
  // R10: illegal-control error is sticky
  a_r10_ill_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_illegal_q |=> err_illegal_q);
endmodule

// File: rtl/link_pwr_sequencer.sv
module link_pwr_sequencer
  import lps_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_state,
  input  logic          want_detlb,
  input  logic          want_idle,
  input  logic          want_beacon,
  input  logic [TW-1:0] done_limit,
  input  logic          phy_done,
  output logic [1:0]    phy_powerdown,
  output logic          phy_tx_detlb,
  output logic          phy_tx_idle,
  output logic [1:0]    cur_state,
  output logic          busy,
  output logic          err_illegal,
  output logic          err_timeout
);
  logic    start, expire, busy_w;
  pstate_e pd_w, cur_w;

  lps_req_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_state     (pstate_e'(req_state)),
    .req_ready     (req_ready),
    .phy_done      (phy_done),
    .expire        (expire),
    .start         (start),
    .busy_q        (busy_w),
    .pd_q          (pd_w),
    .cur_q         (cur_w),
    .err_timeout_q (err_timeout)
  );

  lps_done_watchdog #(.TW(TW)) u_wdog (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .busy     (busy_w),
    .phy_done (phy_done),
    .limit    (done_limit),
    .expire   (expire)
  );

  lps_tx_gate u_gate (
    .clk           (clk),
    .rst_n         (rst_n),
    .cur           (cur_w),
    .want_detlb    (want_detlb),
    .want_idle     (want_idle),
    .want_beacon   (want_beacon),
    .tx_detlb_q    (phy_tx_detlb),
    .tx_idle_q     (phy_tx_idle),
    .err_illegal_q (err_illegal)
  );

  assign phy_powerdown = pd_w;
  assign cur_state     = cur_w;
  assign busy          = busy_w;

  // R3: never ready while a transition is outstanding
  a_r3_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$past(phy_done)) |-> !req_ready);
endmodule

// File: tb/sim_link_pwr_sequencer.sv
module sim_link_pwr_sequencer;
  localparam int TW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, want_detlb = 1'b0, want_idle = 1'b1, want_beacon = 1'b0, phy_done = 1'b0;
  logic [1:0] req_state = 2'b00;
  logic [TW-1:0] done_limit = 16;
  logic req_ready, phy_tx_detlb, phy_tx_idle, busy, err_illegal, err_timeout;
  logic [1:0] phy_powerdown, cur_state;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  link_pwr_sequencer #(.TW(TW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_state(req_state), .want_detlb(want_detlb), .want_idle(want_idle),
    .want_beacon(want_beacon), .done_limit(done_limit), .phy_done(phy_done),
    .phy_powerdown(phy_powerdown), .phy_tx_detlb(phy_tx_detlb),
    .phy_tx_idle(phy_tx_idle), .cur_state(cur_state), .busy(busy),
    .err_illegal(err_illegal), .err_timeout(err_timeout)
  );

  // behavioural reference
  int m_pd = 3, m_cur = 3, m_busy = 0, m_wait = 0, m_det = 0, m_idle = 1, m_ill = 0, m_to = 0;
  int m_ctl_state = 3;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pd = 3; m_cur = 3; m_busy = 0; m_wait = 0;
      m_det = 0; m_idle = 1; m_ill = 0; m_to = 0; m_ctl_state = 3;
    end else begin
      int lim;
      lim = (done_limit == 0) ? 1 : int'(done_limit);
      m_ctl_state = m_cur;
      case (m_cur)
        0: begin m_det = want_detlb; m_idle = want_idle; end
        1: begin m_det = 0; m_idle = 1; if (want_detlb || !want_idle) m_ill = 1; end
        2: begin m_det = want_detlb; m_idle = 1; if (!want_idle) m_ill = 1; end
        default: begin m_det = 0; m_idle = want_beacon ? 0 : 1; if (want_detlb) m_ill = 1; end
      endcase
      if (m_busy == 1 && phy_done) begin
        m_cur = m_pd; m_busy = 0;
      end else if (m_busy == 1 && m_wait + 1 >= lim) begin
        m_busy = 0; m_pd = m_cur; m_to = 1;
      end else if (m_busy == 0 && req_valid) begin
        m_pd = int'(req_state); m_busy = 1; m_wait = 0;
      end else if (m_busy == 1) begin
        m_wait = m_wait + 1;
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic string ctl_req(input int st);
    case (st)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  // compare against the reference on every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2", "powerdown", int'(phy_powerdown), m_pd);
      chk("R3", "busy", int'(busy), m_busy);
      chk("R3", "ready", int'(req_ready), m_busy == 1 ? 0 : 1);
      chk("R4", "cur_state", int'(cur_state), m_cur);
      chk(ctl_req(m_ctl_state), "tx_detlb", int'(phy_tx_detlb), m_det);
      chk(ctl_req(m_ctl_state), "tx_idle", int'(phy_tx_idle), m_idle);
      chk("R10", "err_illegal", int'(err_illegal), m_ill);
      chk("R9", "err_timeout", int'(err_timeout), m_to);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // issue a request and answer it after d busy cycles
  task automatic go(input logic [1:0] st, input int d);
    @(negedge clk);
    req_valid = 1'b1; req_state = st;
    @(negedge clk);
    req_valid = 1'b0;
    cyc(d - 1);
    phy_done = 1'b1;
    @(negedge clk);
    phy_done = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int cnt;
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "powerdown", int'(phy_powerdown), 3);
    chk("R1", "cur_state", int'(cur_state), 3);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "ready", int'(req_ready), 1);
    chk("R1", "tx_idle", int'(phy_tx_idle), 1);
    chk("R1", "tx_detlb", int'(phy_tx_detlb), 0);
    chk("R1", "errors", int'({err_illegal, err_timeout}), 0);

    // R2: first request toward P0
    req_valid = 1'b1; req_state = 2'b00;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2", "powerdown after issue", int'(phy_powerdown), 0);
    chk("R2", "busy after issue", int'(busy), 1);
    phy_done = 1'b1;
    @(negedge clk);
    phy_done = 1'b0;
    chk("R4", "cur after done", int'(cur_state), 0);
    chk("R4", "busy after done", int'(busy), 0);

    // R5: P0 controls pass through
    want_detlb = 1'b1; want_idle = 1'b0;
    cyc(2);
    chk("R5", "loopback", int'(phy_tx_detlb), 1);
    chk("R5", "idle low", int'(phy_tx_idle), 0);
    want_detlb = 1'b0; want_idle = 1'b1;
    cyc(2);
    chk("R5", "normal idle", int'({phy_tx_detlb, phy_tx_idle}), 1);
    chk("R5", "no error", int'(err_illegal), 0);

    // R4: stray completion ignored
    phy_done = 1'b1;
    @(negedge clk);
    phy_done = 1'b0;
    @(negedge clk);
    chk("R4", "stray done cur", int'(cur_state), 0);
    chk("R4", "stray done busy", int'(busy), 0);

    // R3: request held off while busy
    req_valid = 1'b1; req_state = 2'b10;
    @(negedge clk);
    req_state = 2'b01;
    cyc(3);
    chk("R3", "powerdown held", int'(phy_powerdown), 2);
    chk("R3", "ready low", int'(req_ready), 0);
    phy_done = 1'b1; req_valid = 1'b0;
    @(negedge clk);
    phy_done = 1'b0;
    chk("R4", "cur P1", int'(cur_state), 2);
    @(negedge clk);
    chk("R3", "no late accept", int'(phy_powerdown), 2);
    chk("R3", "not busy", int'(busy), 0);

    // R7: P1 receiver detect
    want_detlb = 1'b1;
    cyc(2);
    chk("R7", "detect", int'(phy_tx_detlb), 1);
    chk("R7", "idle high", int'(phy_tx_idle), 1);
    want_detlb = 1'b0; want_beacon = 1'b1;
    cyc(2);
    chk("R8", "beacon ignored in P1", int'(phy_tx_idle), 1);
    want_beacon = 1'b0;

    // R8: P2 beacon
    go(2'b11, 3);
    chk("R4", "cur P2", int'(cur_state), 3);
    want_beacon = 1'b1;
    cyc(2);
    chk("R8", "beacon idle low", int'(phy_tx_idle), 0);
    want_beacon = 1'b0; want_idle = 1'b0;
    cyc(2);
    chk("R8", "idle request ignored", int'(phy_tx_idle), 1);
    chk("R8", "no error", int'(err_illegal), 0);
    want_idle = 1'b1;

    // R6: P0s
    go(2'b01, 1);
    cyc(1);
    chk("R6", "legal levels", int'({phy_tx_detlb, phy_tx_idle}), 1);
    chk("R6", "no error yet", int'(err_illegal), 0);
    want_detlb = 1'b1;
    cyc(2);
    chk("R6", "detlb forced low", int'(phy_tx_detlb), 0);
    chk("R6", "illegal flagged", int'(err_illegal), 1);
    want_detlb = 1'b0;
    cyc(3);
    chk("R10", "illegal sticky", int'(err_illegal), 1);

    // R9: timeout with limit 4
    done_limit = 4;
    req_valid = 1'b1; req_state = 2'b10;
    @(negedge clk);
    req_valid = 1'b0;
    cnt = 0;
    while (busy && cnt < 50) begin cnt++; @(negedge clk); end
    chk("R9", "busy cycles", cnt, 4);
    chk("R9", "timeout flag", int'(err_timeout), 1);
    chk("R9", "powerdown restored", int'(phy_powerdown), 1);
    chk("R9", "cur unchanged", int'(cur_state), 1);
    phy_done = 1'b1;
    @(negedge clk);
    phy_done = 1'b0;
    @(negedge clk);
    chk("R9", "late done ignored", int'(cur_state), 1);

    // R9: limit 0 behaves as 1
    done_limit = 0;
    req_valid = 1'b1; req_state = 2'b00;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9", "busy one cycle", int'(busy), 1);
    @(negedge clk);
    chk("R9", "released", int'(busy), 0);
    chk("R9", "code back", int'(phy_powerdown), 1);

    // R9: completion on the expiry edge wins
    done_limit = 2;
    req_valid = 1'b1; req_state = 2'b00;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    phy_done = 1'b1;
    @(negedge clk);
    phy_done = 1'b0;
    chk("R9", "done wins", int'(cur_state), 0);
    chk("R10", "timeout sticky", int'(err_timeout), 1);
    cyc(3);
    finish_run();
  end
endmodule